// File: doc/BRIEF.md
# Dual-Lane DDR ADC Sample Deserializer

This block turns the serial output of a multi-channel ADC back into parallel samples. Each channel sends one sample word per frame, split across two serial lanes. The first lane carries the upper half of the word and the second lane carries the lower half. Both lanes are sampled on the rising and the falling edge of a bit clock that the ADC forwards with the data. The ADC also sends a frame clock. The block deserializes that frame clock in the same way as a data lane and uses it to find the word boundary.

When the deserialized frame-clock word does not show the expected pattern, the block issues a one-bit slip. The slip moves the word window of every lane by one bit position. The block then ignores two frames before it checks the pattern again. After several consecutive frames match, the block reports that it is aligned. Once per frame it presents one parallel word per channel together with a single-cycle valid strobe.

The bits per lane and the channel count are parameters. All channels share one bit clock, one frame clock and one alignment controller.

Top module: `adc_ddr_deser`

## Requirements
- R1: For channel c, `word_out[c*2W +: 2W]` equals the W bits received on `lane_a[c]` in one frame, placed above the W bits received on `lane_b[c]` in the same frame. W is `LANE_BITS`, 7 by default.
- R2: Each lane carries one bit per clock edge. Within a frame the bits arrive MSB first, and in each bit-clock period the bit sampled at the rising edge comes before the bit sampled at the falling edge.
- R3: All channels are rebuilt in parallel from the same frame boundary, and each channel's word depends only on its own two lanes.
- R4: The expected frame-clock word has its upper W - floor(W/2) bits at 1 and the rest at 0, which is binary 1111000 for W=7. When a completed frame-clock word differs from this pattern, the block issues a one-cycle slip. The slip moves the word boundary of every lane by one bit. The next two frames are then ignored before the pattern is checked again.
- R5: `aligned` rises only after 4 consecutive frames have matched the pattern, so at least 4 `word_valid` pulses occur after reset before `aligned` goes high. A single mismatching frame clears `aligned` and restarts the search.
- R6: `word_valid` is high for exactly one clock cycle per frame. While the block is aligned the gap between pulses is 3 or 4 bit-clock cycles (for W=7), and `word_out` changes only together with `word_valid`. Consecutive frames appear in order, with none skipped or repeated.
- R7: `rst_n` low clears `word_out` to zero and drives `word_valid` and `aligned` low at once. Internal operation resumes two bit-clock edges after `rst_n` is released.
- R8: From any starting bit offset of the serial stream, `aligned` is reached within 400 bit-clock cycles, and the words presented afterwards are correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Forwarded bit clock; data is sampled on both of its edges |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lane_a | input | CHANNELS | Upper-half serial lane for each channel |
| lane_b | input | CHANNELS | Lower-half serial lane for each channel |
| frame_in | input | 1 | Frame clock from the ADC, sampled like a data lane |
| word_out | output | CHANNELS*2*LANE_BITS | Rebuilt sample words, with channel 0 in the least significant slot |
| word_valid | output | 1 | One-cycle strobe each time a new set of words is presented |
| aligned | output | 1 | High while the frame boundary is locked |

## Verification
The stream is started at each of the seven possible bit offsets relative to the frame, so the slip search must rotate through every window position before it locks. A table of sample values is used as stimulus: all zeros, all ones, alternating bits, a single MSB, a single LSB and mixed values. These values tell apart swapped lanes, swapped rising and falling bits, reversed bit order and a window that is off by one bit. Each channel receives a different position in that table, which exposes crossed channels. One frame-clock period is then corrupted during lock, to show that `aligned` drops, the search restarts, and the block relocks with the data still in order.

// File: rtl/adc_des_pkg.sv
package adc_des_pkg;

  typedef enum logic [1:0] {
    AL_HUNT = 2'd0,
    AL_WAIT = 2'd1,
    AL_LOCK = 2'd2
  } align_st_e;

  // Frame-clock word expected at a correct boundary: upper half (rounded up) ones.
  function automatic logic [31:0] frame_pattern(input int w);
    logic [31:0] p;
    p = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < w && i >= w / 2) p[i] = 1'b1;
    end
    return p;
  endfunction

endpackage

// File: rtl/ddr_capture.sv
module ddr_capture #(
  parameter int LANES = 5
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] rise_q,
  output logic [LANES-1:0] fall_q
);

  // Rising-edge bit: first bit of each bit-clock period.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rise_q <= '0;
    else         rise_q <= din;
  end

  // Falling-edge bit: second bit, paired with rise_q at the next rising edge.
  always_ff @(negedge clk or negedge rst_ni) begin
    if (!rst_ni) fall_q <= '0;
    else         fall_q <= din;
  end

endmodule

// File: rtl/lane_gearbox.sv
module lane_gearbox #(
  parameter int W     = 7,
  parameter int LANES = 5
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [LANES-1:0]   rise_bits,
  input  logic [LANES-1:0]   fall_bits,
  input  logic [1:0]         extra_sel,
  output logic [LANES*W-1:0] words
);

  localparam int HW = W + 2;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [HW-1:0] hist_q;
    logic [HW-1:0] shifted;

    // Two bits per rising edge, older (rising) bit lands above newer (falling).
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) hist_q <= '0;
      else         hist_q <= {hist_q[HW-3:0], rise_bits[i], fall_bits[i]};
    end

    // extra_sel newest bits already belong to the next word.
    assign shifted          = hist_q >> extra_sel;
    assign words[i*W +: W]  = shifted[W-1:0];
  end

endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
  import adc_des_pkg::*;
#(
  parameter int W      = 7,
  parameter int LOCK_N = 4,
  parameter int WAIT_N = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] frame_word,
  output logic         word_stb,
  output logic [1:0]   extra_q,
  output logic         slip_q,
  output logic         aligned_q
);

  localparam int AW = $clog2(W + 3) + 1;
  localparam int MW = $clog2(LOCK_N + 1);
  localparam int CW = $clog2(WAIT_N + 1);
  localparam logic [W-1:0] EXP = W'(frame_pattern(W));

  logic [AW-1:0] acc_q, acc_n, sum;
  logic          done_q, done_n;
  logic [1:0]    extra_n;
  align_st_e     st_q, st_n;
  logic [MW-1:0] mcnt_q, mcnt_n;
  logic [CW-1:0] wcnt_q, wcnt_n;
  logic          slip_n, al_n;

  // Bit-position accumulator: 2 bits per cycle, one extra when slipping.
  always_comb begin
    sum     = acc_q + AW'(2) + AW'(slip_q);
    done_n  = (sum >= AW'(W));
    acc_n   = done_n ? (sum - AW'(W)) : sum;
    extra_n = done_n ? acc_n[1:0] : 2'd0;
  end

  // Alignment controller next state.
  always_comb begin
    st_n   = st_q;
    mcnt_n = mcnt_q;
    wcnt_n = wcnt_q;
    slip_n = 1'b0;
    al_n   = aligned_q;
    if (done_q) begin
      unique case (st_q)
        AL_HUNT, AL_LOCK: begin
          if (frame_word == EXP) begin
            if (mcnt_q == MW'(LOCK_N - 1)) begin
              al_n = 1'b1;
              st_n = AL_LOCK;
            end else begin
              mcnt_n = mcnt_q + MW'(1);
            end
          end else begin
            slip_n = 1'b1;
            al_n   = 1'b0;
            mcnt_n = '0;
            wcnt_n = '0;
            st_n   = AL_WAIT;
          end
        end
        AL_WAIT: begin
          if (wcnt_q == CW'(WAIT_N - 1)) begin
            wcnt_n = '0;
            st_n   = AL_HUNT;
          end else begin
            wcnt_n = wcnt_q + CW'(1);
          end
        end
        default: st_n = AL_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      done_q    <= 1'b0;
      extra_q   <= 2'd0;
      st_q      <= AL_HUNT;
      mcnt_q    <= '0;
      wcnt_q    <= '0;
      slip_q    <= 1'b0;
      aligned_q <= 1'b0;
    end else begin
      acc_q     <= acc_n;
      done_q    <= done_n;
      extra_q   <= extra_n;
      st_q      <= st_n;
      mcnt_q    <= mcnt_n;
      wcnt_q    <= wcnt_n;
      slip_q    <= slip_n;
      aligned_q <= al_n;
    end
  end

  assign word_stb = done_q;

  // R4: a slip lasts exactly one cycle
  a_r4_slip_single: assert property (@(posedge clk) disable iff (!rst_ni)
    slip_q |=> !slip_q);
  // R4: a slip only follows a completed frame word
  a_r4_slip_after_frame: assert property (@(posedge clk) disable iff (!rst_ni)
    slip_q |-> $past(done_q));
  // R5: lock is only granted on a frame word
  a_r5_lock_on_frame: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(aligned_q) |-> $past(done_q));
  // R5: losing lock always restarts the search with a slip
  a_r5_drop_slips: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(aligned_q) |-> slip_q);
  // R6: bit position stays inside one word
  a_r6_acc_range: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_q < AW'(W));

endmodule

// File: rtl/adc_ddr_deser.sv
module adc_ddr_deser #(
  parameter int LANE_BITS = 7,
  parameter int CHANNELS  = 2
) (
  input  logic                            clk_bit,
  input  logic                            rst_n,
  input  logic [CHANNELS-1:0]             lane_a,
  input  logic [CHANNELS-1:0]             lane_b,
  input  logic                            frame_in,
  output logic [CHANNELS*2*LANE_BITS-1:0] word_out,
  output logic                            word_valid,
  output logic                            aligned
);

  localparam int W  = LANE_BITS;
  localparam int SW = 2 * W;
  localparam int NL = 2 * CHANNELS + 1;

  logic [1:0]             rs_q;
  logic                   rst_ni;
  logic [NL-1:0]          din, rise_q, fall_q;
  logic [NL*W-1:0]        words;
  logic [1:0]             extra_q;
  logic                   word_stb, slip_q, aligned_q;
  logic [CHANNELS*SW-1:0] assembled, word_q;
  logic                   valid_q;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  assign din = {frame_in, lane_b, lane_a};

  ddr_capture #(.LANES(NL)) u_cap (
    .clk    (clk_bit),
    .rst_ni (rst_ni),
    .din    (din),
    .rise_q (rise_q),
    .fall_q (fall_q)
  );

  lane_gearbox #(.W(W), .LANES(NL)) u_gbx (
    .clk       (clk_bit),
    .rst_ni    (rst_ni),
    .rise_bits (rise_q),
    .fall_bits (fall_q),
    .extra_sel (extra_q),
    .words     (words)
  );

  frame_aligner #(.W(W), .LOCK_N(4), .WAIT_N(2)) u_aln (
    .clk        (clk_bit),
    .rst_ni     (rst_ni),
    .frame_word (words[2*CHANNELS*W +: W]),
    .word_stb   (word_stb),
    .extra_q    (extra_q),
    .slip_q     (slip_q),
    .aligned_q  (aligned_q)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    assign assembled[c*SW +: SW] = {words[c*W +: W], words[(CHANNELS+c)*W +: W]};
  end

  always_ff @(posedge clk_bit or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= word_stb;
      if (word_stb) word_q <= assembled;
    end
  end

  assign word_out   = word_q;
  assign word_valid = valid_q;
  assign aligned    = aligned_q;

  // R6: one-cycle strobe per frame
  a_r6_valid_single: assert property (@(posedge clk_bit) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R6: output words only change with the strobe
  a_r6_word_with_valid: assert property (@(posedge clk_bit) disable iff (!rst_ni)
    !$stable(word_q) |-> valid_q);
  // R4: when slipping, lock cannot be held
  a_r4_no_slip_locked: assert property (@(posedge clk_bit) disable iff (!rst_ni)
    slip_q |-> !aligned_q);

endmodule

// File: tb/tb_adc_ddr_deser.sv
`timescale 1ns/1ps
module tb_adc_ddr_deser;

  localparam int CLK_PERIOD = 20;
  localparam int Q  = CLK_PERIOD / 4;
  localparam int W  = 7;
  localparam int SW = 2 * W;
  localparam int CH = 2;
  localparam int NT = 8;
  localparam logic [SW-1:0] TBL [NT] = '{
    14'h0000, 14'h3FFF, 14'h2AAA, 14'h1555,
    14'h2000, 14'h0001, 14'h1234, 14'h3C0F
  };

  logic            clk_bit, rst_n, frame_in;
  logic [CH-1:0]   lane_a, lane_b;
  logic [CH*SW-1:0] word_out;
  logic            word_valid, aligned;

  int bpos, bit_off, glitch_s;
  int checks, errors;

  adc_ddr_deser #(.LANE_BITS(W), .CHANNELS(CH)) dut (
    .clk_bit (clk_bit), .rst_n (rst_n), .lane_a (lane_a), .lane_b (lane_b),
    .frame_in (frame_in), .word_out (word_out), .word_valid (word_valid),
    .aligned (aligned)
  );

  // Stream generator: global bit g, MSB first, sample s, position p.
  task automatic drive(input int g);
    int s, p;
    s = g / W;
    p = g % W;
    for (int c = 0; c < CH; c++) begin
      lane_a[c] = TBL[(s + c) % NT][SW-1-p];
      lane_b[c] = TBL[(s + c) % NT][W-1-p];
    end
    frame_in = (p < W - W / 2);
    if (s == glitch_s) frame_in = ~frame_in;
  endtask

  // Clock and DDR data together: data changes a quarter period before each edge.
  initial begin
    clk_bit = 1'b0; bpos = 0; bit_off = 0; glitch_s = -1;
    lane_a = '0; lane_b = '0; frame_in = 1'b0;
    forever begin
      drive(bpos + bit_off);
      #Q clk_bit = 1'b1;
      #Q drive(bpos + bit_off + 1);
      #Q clk_bit = 1'b0;
      #Q bpos += 2;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_bit);
    #1;
  endtask

  // Wait for lock; counts valid pulses seen before it.
  task automatic wait_lock(input string req, output int pulses);
    int n;
    n = 0; pulses = 0;
    while (!aligned && n < 400) begin
      cyc();
      if (word_valid) pulses++;
      n++;
    end
    check(aligned, req, aligned, 1);
  endtask

  // Check n consecutive frames against the table, in order, all channels.
  task automatic check_words(input int n);
    int idx, got, gap, last, guard;
    idx = -1; got = 0; last = -1; guard = 0; gap = 0;
    while (got < n && guard < 200) begin
      cyc();
      guard++;
      gap++;
      if (word_valid) begin
        if (last >= 0)
          check(gap == 3 || gap == 4, "R6 valid spacing", gap, 3);
        last = 0; gap = 0;
        if (idx < 0) begin
          for (int k = 0; k < NT; k++)
            if (word_out[SW-1:0] == TBL[k]) idx = k;
          check(idx >= 0, "R1/R2 first word in table", int'(word_out[SW-1:0]), 0);
          if (idx < 0) idx = 0;
        end else begin
          idx = (idx + 1) % NT;
        end
        for (int c = 0; c < CH; c++)
          check(word_out[c*SW +: SW] == TBL[(idx + c) % NT],
                (c == 0) ? "R1 R2 R6 channel word" : "R3 channel word",
                int'(word_out[c*SW +: SW]), int'(TBL[(idx + c) % NT]));
        got++;
      end
    end
    check(got == n, "R6 frame count", got, n);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pulses, n;
    checks = 0; errors = 0;
    rst_n = 1'b0;
    repeat (3) cyc();
    // R7: reset state
    check(word_out == '0, "R7 word_out in reset", int'(word_out[SW-1:0]), 0);
    check(!word_valid, "R7 valid in reset", word_valid, 0);
    check(!aligned, "R7 aligned in reset", aligned, 0);

    // R8 / R4: every starting offset must be found by slipping
    for (int off = 0; off < W; off++) begin
      rst_n = 1'b0;
      bit_off = off;
      repeat (2) cyc();
      rst_n = 1'b1;
      wait_lock("R8 lock from offset", pulses);
      check(pulses >= 4, "R5 lock needs 4 frames", pulses, 4);
      check_words(10);
    end

    // R5: corrupted frame clock drops lock, then R8 relock
    glitch_s = (bpos + bit_off) / W + 3;
    n = 0;
    while (aligned && n < 60) begin cyc(); n++; end
    check(!aligned, "R5 mismatch clears aligned", aligned, 0);
    wait_lock("R8 relock after mismatch", pulses);
    check(pulses >= 4, "R5 relock needs 4 frames", pulses, 4);
    check_words(8);

    // R7: asynchronous reset mid-run
    #3 rst_n = 1'b0;
    #1;
    check(word_out == '0, "R7 async clear word", int'(word_out[SW-1:0]), 0);
    check(!aligned && !word_valid, "R7 async clear flags", aligned, 0);
    cyc();
    rst_n = 1'b1;
    cyc();
    check(!word_valid && !aligned, "R7 held during release", word_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule